// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, given as a segment number and an offset, into a physical address. It holds a small segment table in flip-flops. Each entry carries a start address (base), a length (limit) and a valid bit. A write port loads and clears the entries.

For each request the block selects the entry that the segment number points to. It checks the offset against that entry's own limit before any addition. If the check passes, it returns base plus offset. Otherwise it flags an invalid-address error. Every bound check uses the limit of the selected segment, so there is no single relocation and limit pair shared by all segments.

The answer is registered. A response appears exactly one clock after each request, so an upstream address generator can issue one translation per cycle with no stall logic.

Top module: `seg_xlate`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `rsp_valid`=0, `rsp_err`=0 and `rsp_addr`=0. Every table entry is left invalid.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: If the selected entry is valid and `req_off` is strictly less than its limit, the response has `rsp_err`=0 and `rsp_addr` = base + `req_off`, taken modulo 2^ADDR_W.
- R4: If `req_off` is greater than or equal to the selected entry's limit, the response has `rsp_err`=1. An offset equal to the limit is out of range.
- R5: A segment number of NUM_SEG or more (6 or 7 by default) gives `rsp_err`=1.
- R6: A segment whose entry has never been written, or was last written with `wr_vld`=0, gives `rsp_err`=1.
- R7: A write and a request in the same cycle: the request is translated with the table contents from before the write. The write takes effect from the next cycle.
- R8: A write whose index is NUM_SEG or more changes no entry.
- R9: `rsp_err` is high only together with `rsp_valid`. `rsp_addr` is 0 whenever `rsp_err` is high or `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load one table entry this cycle |
| wr_idx | input | SEG_W (3) | Entry to load |
| wr_base | input | ADDR_W (16) | Segment start address |
| wr_limit | input | OFF_W (12) | Segment length |
| wr_vld | input | 1 | Valid bit stored with the entry |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W (3) | Segment number of the request |
| req_off | input | OFF_W (12) | Offset within the segment |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Invalid-address error for this response |
| rsp_addr | output | ADDR_W (16) | Translated physical address |

## Verification
Every response is due exactly one rising edge after its request. Table writes are seen by requests from the following edge on.

The bench drives inputs on falling edges. A behavioural model updates at each rising edge and first uses the table from before that edge's write. The outputs are compared on the next falling edge, one register after the stimulus. Directed checks read the response on the falling edge right after the request cycle, and the same one-cycle spacing applies to the same-cycle write-and-read case.

// File: rtl/seg_xlate_pkg.sv
// Shared definitions for the segment translator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package seg_xlate_pkg;

    // Outcome of one lookup, ordered by which test fails first.
    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_NOSEG = 2'd1,
        XS_EMPTY = 2'd2,
        XS_LIMIT = 2'd3
    } xlate_stat_e;

endpackage

// File: rtl/seg_table.sv
// Segment table held in flip-flops, one entry per segment.
// What it does: stores base, limit and a valid bit per entry. Reads
// combinationally by segment number.
// Assumes: NUM_SEG <= 2**SEG_W. Writes to indices at or past NUM_SEG
// are dropped.
module seg_table #(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3,
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [OFF_W-1:0]  wr_limit,
    input  logic              wr_vld,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic              rd_inr,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_base,
    output logic [OFF_W-1:0]  rd_limit
);
    logic [NUM_SEG-1:0] ent_vld;
    logic [ADDR_W-1:0]  ent_base  [NUM_SEG];
    logic [OFF_W-1:0]   ent_limit [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        // Load one entry on a matching write; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g]   <= 1'b0;
                ent_base[g]  <= '0;
                ent_limit[g] <= '0;
            end else if (wr_en && wr_idx == SEG_W'(g)) begin
                ent_vld[g]   <= wr_vld;
                ent_base[g]  <= wr_base;
                ent_limit[g] <= wr_limit;
            end
        end
    end

    // Select the addressed entry; out-of-range indices read as empty.
    always_comb begin
        rd_inr   = 1'b0;
        rd_vld   = 1'b0;
        rd_base  = '0;
        rd_limit = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_W'(i)) begin
                rd_inr   = 1'b1;
                rd_vld   = ent_vld[i];
                rd_base  = ent_base[i];
                rd_limit = ent_limit[i];
            end
        end
    end
endmodule

// File: rtl/seg_check.sv
// Bound check and relocation for one lookup.
// What it does: classifies the lookup and forms base plus offset.
// Assumes: ADDR_W > OFF_W; the sum wraps modulo 2**ADDR_W.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12
) (
    input  logic              ent_inr,
    input  logic              ent_vld,
    input  logic [ADDR_W-1:0] ent_base,
    input  logic [OFF_W-1:0]  ent_limit,
    input  logic [OFF_W-1:0]  off,
    output xlate_stat_e       stat,
    output logic [ADDR_W-1:0] phys
);
    localparam int PAD_W = ADDR_W - OFF_W;

    // Pick the first failing test; the limit test precedes the add.
    always_comb begin
        if (!ent_inr)               stat = XS_NOSEG;
        else if (!ent_vld)          stat = XS_EMPTY;
        else if (off >= ent_limit)  stat = XS_LIMIT;
        else                        stat = XS_OK;
    end

    // Relocate the offset by the segment base.
    always_comb phys = ent_base + {{PAD_W{1'b0}}, off};
endmodule

// File: rtl/seg_xlate.sv
// Segment base-limit translator, top level.
// What it does: loads a segment table and translates (segment, offset)
// into a physical address. The response is registered one cycle later.
// Assumes: one request per cycle at most; the requester accepts every
// response.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3,
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [OFF_W-1:0]  wr_limit,
    input  logic              wr_vld,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr
);
    logic              rd_inr;
    logic              rd_vld;
    logic              rd_ok;
    logic [ADDR_W-1:0] rd_base;
    logic [OFF_W-1:0]  rd_limit;
    logic [ADDR_W-1:0] phys;
    xlate_stat_e       stat;

    seg_table #(
        .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_vld(wr_vld),
        .rd_idx(req_seg), .rd_inr(rd_inr), .rd_vld(rd_vld),
        .rd_base(rd_base), .rd_limit(rd_limit)
    );

    // Entry usable: inside the table and marked valid.
    assign rd_ok = rd_inr && rd_vld;

    seg_check #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_check (
        .ent_inr(rd_inr), .ent_vld(rd_vld), .ent_base(rd_base),
        .ent_limit(rd_limit), .off(req_off), .stat(stat), .phys(phys)
    );

    // Register the response; the address is cleared unless the lookup passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (stat != XS_OK);
            rsp_addr  <= (req_valid && stat == XS_OK) ? phys : '0;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Assertion checker for seg_xlate, attached by bind.
// What it does: relates the table read side to the registered response.
// Assumes: ADDR_W > OFF_W.
module seg_xlate_chk #(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3,
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SEG_W-1:0]  req_seg,
    input logic [OFF_W-1:0]  req_off,
    input logic              rd_ok,
    input logic [ADDR_W-1:0] rd_base,
    input logic [OFF_W-1:0]  rd_limit,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] rsp_addr
);
    localparam int PAD_W = ADDR_W - OFF_W;
    logic [ADDR_W-1:0] sum_c;
    assign sum_c = rd_base + {{PAD_W{1'b0}}, req_off};

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_err && rsp_addr == '0));

    p_req_to_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_in_range_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_ok && req_off < rd_limit)
        |=> (!rsp_err && rsp_addr == $past(sum_c)));

    p_over_limit_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_off >= rd_limit) |=> rsp_err);

    p_seg_oob_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_seg) >= NUM_SEG) |=> rsp_err);

    p_empty_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rd_ok) |=> rsp_err);

    p_err_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_addr == '0));

    p_idle_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_addr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/test_seg_xlate.sv
// Bench for seg_xlate: behavioural reference model compared every cycle,
// plus directed checks on known vectors and corner cases.
module test_seg_xlate;
    localparam int NSEG = 6;
    localparam int SW   = 3;
    localparam int AW   = 16;
    localparam int OW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_idx = '0;
    logic [AW-1:0] wr_base = '0;
    logic [OW-1:0] wr_limit = '0;
    logic          wr_vld = 1'b0;
    logic          req_valid = 1'b0;
    logic [SW-1:0] req_seg = '0;
    logic [OW-1:0] req_off = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [AW-1:0] rsp_addr;
    string         note = "";

    int total = 0;
    int bad   = 0;
    bit armed = 1'b0;
    bit done  = 1'b0;

    // Reference state and expectations.
    int    ref_b [8];
    int    ref_l [8];
    bit    ref_v [8];
    bit    e_v = 1'b0;
    bit    e_e = 1'b0;
    int    e_a = 0;
    string e_tag = "R1";

    always #10 clk = ~clk;

    seg_xlate #(.NUM_SEG(NSEG), .SEG_W(SW), .ADDR_W(AW), .OFF_W(OW)) i_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_vld(wr_vld),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr)
    );

    // Model: translate with the old table, then apply the write (R7).
    always @(posedge clk) begin
        if (!rst_n) begin
            e_v = 0; e_e = 0; e_a = 0; e_tag = "R1";
            for (int i = 0; i < 8; i++) begin ref_v[i] = 0; ref_b[i] = 0; ref_l[i] = 0; end
            armed = 1'b1;
        end else begin
            e_v = req_valid; e_e = 0; e_a = 0;
            if (!req_valid) e_tag = "R2";
            else if (req_seg >= NSEG) begin e_e = 1; e_tag = "R5"; end
            else if (!ref_v[req_seg]) begin e_e = 1; e_tag = "R6"; end
            else if (req_off >= ref_l[req_seg]) begin e_e = 1; e_tag = "R4"; end
            else begin e_a = (ref_b[req_seg] + req_off) % (1 << AW); e_tag = "R3"; end
            if (note != "") e_tag = note;
            if (wr_en && wr_idx < NSEG) begin
                ref_v[wr_idx] = wr_vld; ref_b[wr_idx] = wr_base; ref_l[wr_idx] = wr_limit;
            end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            total++;
            if (rsp_valid !== e_v || rsp_err !== e_e || rsp_addr !== AW'(e_a)) begin
                bad++;
                $display("FAIL %s: got v=%0b e=%0b a=%0d exp v=%0b e=%0b a=%0d",
                         e_tag, rsp_valid, rsp_err, rsp_addr, e_v, e_e, e_a);
            end
        end
    end

    // Single-cycle stimulus, then inputs return to idle.
    task automatic drive(input bit we, input int idx, input int b, input int l,
                         input bit v, input bit rq, input int s, input int o,
                         input string tg);
        @(negedge clk);
        wr_en = we; wr_idx = SW'(idx); wr_base = AW'(b); wr_limit = OW'(l); wr_vld = v;
        req_valid = rq; req_seg = SW'(s); req_off = OW'(o); note = tg;
        @(negedge clk);
        wr_en = 0; req_valid = 0; note = "";
    endtask

    task automatic ld(input int idx, input int b, input int l);
        drive(1, idx, b, l, 1, 0, 0, 0, "R8");
    endtask

    // Directed check on the response one cycle after the request.
    task automatic chk(input bit xe, input int xa, input string tg);
        total++;
        if (rsp_valid !== 1'b1 || rsp_err !== xe || rsp_addr !== AW'(xa)) begin
            bad++;
            $display("FAIL %s: got v=%0b e=%0b a=%0d exp v=1 e=%0b a=%0d",
                     tg, rsp_valid, rsp_err, rsp_addr, xe, xa);
        end
    endtask

    task automatic rq(input int s, input int o, input bit xe, input int xa, input string tg);
        drive(0, 0, 0, 0, 0, 1, s, o, tg);
        chk(xe, xa, tg);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (rsp_valid !== 0 || rsp_err !== 0 || rsp_addr !== 0) begin
            bad++;
            $display("FAIL R1: got v=%0b e=%0b a=%0d exp 0 0 0", rsp_valid, rsp_err, rsp_addr);
        end
        rst_n = 1'b1;
        rq(0, 0, 1, 0, "R1");          // table empty after reset
        rq(3, 5, 1, 0, "R6");

        // First table.
        ld(0, 1400, 1000); ld(1, 6300, 400); ld(2, 4300, 400);
        ld(3, 3200, 1100); ld(4, 4700, 1000);
        rq(1, 399, 0, 6699, "R3");
        rq(1, 400, 1, 0, "R4");         // equal to limit
        rq(0, 0, 0, 1400, "R3");
        rq(3, 1099, 0, 4299, "R3");
        rq(4, 1001, 1, 0, "R4");
        rq(5, 0, 1, 0, "R6");
        rq(6, 1, 1, 0, "R5");
        rq(7, 0, 1, 0, "R5");

        // Second table.
        ld(0, 5432, 350); ld(1, 115, 100); ld(2, 2200, 780);
        ld(3, 4235, 1100); ld(4, 1650, 400);
        rq(2, 247, 0, 2447, "R3");
        rq(4, 439, 1, 0, "R4");
        rq(1, 99, 0, 214, "R3");

        // Out-of-table writes touch nothing.
        drive(1, 6, 9, 9, 1, 0, 0, 0, "R8");
        drive(1, 7, 9, 9, 1, 0, 0, 0, "R8");
        for (int s = 0; s < 5; s++) rq(s, 0, 0, (s == 0) ? 5432 : (s == 1) ? 115 :
                                        (s == 2) ? 2200 : (s == 3) ? 4235 : 1650, "R8");
        rq(7, 0, 1, 0, "R8");

        // Same-cycle write and read: old contents answer first.
        drive(1, 2, 100, 50, 1, 1, 2, 10, "R7");
        chk(0, 2210, "R7");
        rq(2, 10, 0, 110, "R7");

        // Clearing the valid bit.
        drive(1, 3, 4235, 1100, 0, 0, 0, 0, "R6");
        rq(3, 1, 1, 0, "R6");

        // Modulo wrap of base plus offset.
        ld(5, 65530, 100);
        rq(5, 10, 0, 4, "R3");

        // Random traffic checked by the model.
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) == 0); wr_idx = SW'($urandom_range(0, 7));
            wr_base = AW'($urandom_range(0, 8000)); wr_limit = OW'($urandom_range(0, 1200));
            wr_vld = ($urandom_range(0, 4) != 0);
            req_valid = $urandom_range(0, 1); req_seg = SW'($urandom_range(0, 7));
            req_off = OW'($urandom_range(0, 1200));
        end
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        repeat (3) @(negedge clk);

        // Reset mid-run empties the table.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rq(2, 0, 1, 0, "R1");
        rq(1, 0, 1, 0, "R9");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        done = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog: got hang exp finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule